// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Edge Interrupts

This block controls a set of general-purpose I/O lines. The lines are divided into two banks at a boundary line index that is set by a parameter. Lines below the boundary belong to the core bank. Lines at or above it belong to the resume bank and use their index minus the boundary as a local index. Software reaches every line through a byte-wide register bus with separate read and write strobes. For each line it can set:

- whether the line is enabled;
- its direction and its driven level;
- which edges are detected;
- whether a captured edge is routed to the interrupt output, or to a stored system-management route bit.

Input pins pass through a two-flop synchroniser before edge detection. A detected edge sets a sticky status bit, and software clears that bit by writing 1 to it. A single level-sensitive interrupt output merges the routed status of both banks.

The default build has 14 lines with the boundary at 10. Lines 8, 9 and 13 come out of reset disabled, so software must enable them before use.

Top module: `gpio_dualbank_ctrl`

## Requirements
- R1: Reset state:
  - every line is an input (direction 1);
  - all edge, interrupt-route and management-route enables are 0, and all status bits are 0;
  - output levels are 0, `irq` is 0 and no line drives;
  - the enable register takes the parameter `EN_INIT`, which by default enables lines 0-7 and 10-12.
- R2: Address map:
  - `addr[5]` selects the bank: 0 for core at 0x00, 1 for resume at 0x20.
  - `addr[4:2]` selects the register: enable 0, direction 1, level 2, rising enable 3, falling enable 4, interrupt route 5, management route 6, status 7. The byte offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C.
  - `addr[1:0]` selects the byte, equal to local index / 8. The bit position is local index mod 8.
- R3: A direction bit of 1 makes the line an input and 0 makes it an output. `pins_oe[i]` is 1 exactly when line i is enabled and is an output.
- R4: Level register:
  - A write to the level bit of an input line has no effect.
  - For an output line, the written level appears on `pins_out` one cycle after the write.
  - Reading an input line's level bit returns the synchronised pin.
  - Reading an output line's level bit returns the driven value.
- R5: Edge detection:
  - The rising-edge and falling-edge enables act independently. With both set, either edge sets status; with neither set, nothing is latched.
  - A pin change made between clock edges sets status on the third rising clock edge after it, and not before.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and status never clears without a write.
- R7: If an edge and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly while some status bit in either bank has its interrupt-route bit set. The management-route bit is only stored and read back; it does not affect `irq`.
- R9: A disabled line never drives, never latches status, and reads 0 in its level bit.
- R10: `rdata` updates on the clock edge where `rd_en` is high and holds otherwise. A read of a byte beyond a bank's line count returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pins_in | input | N | Pin input levels (asynchronous) |
| pins_out | output | N | Driven output levels |
| pins_oe | output | N | Output enables per line |
| irq | output | 1 | Combined level interrupt |

## Verification
The assertions check the following on every cycle:
- an input line's driven level never changes;
- no disabled line and no input line drives;
- status bits never clear without a bus write;
- new status bits appear only on lines that are enabled and armed for an edge;
- `irq` is low whenever no routed status is pending.

Only the bench scenarios can show the remaining behaviour:
- the exact three-cycle edge latency;
- the choice between edge polarities;
- the set-wins collision;
- address decoding across both banks;
- the reset defaults;
- the gating of `irq` by the route bits.

// File: rtl/gpio_dualbank_pkg.sv
package gpio_dualbank_pkg;

    // Register select field: addr[4:2] of the byte address.
    typedef enum logic [2:0] {
        SEL_ENABLE    = 3'd0,
        SEL_DIR       = 3'd1,
        SEL_LEVEL     = 3'd2,
        SEL_RISE_EN   = 3'd3,
        SEL_FALL_EN   = 3'd4,
        SEL_IRQ_ROUTE = 3'd5,
        SEL_SMI_ROUTE = 3'd6,
        SEL_STATUS    = 3'd7
    } reg_sel_e;

    localparam int ADDR_W    = 6;
    localparam int MAX_BYTES = 4;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_lvl,
    output logic [W-1:0] pin_rise,
    output logic [W-1:0] pin_fall
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pin_async;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pin_lvl  = sync_q.s2;
    assign pin_rise = sync_q.s2 & ~sync_q.s3;
    assign pin_fall = ~sync_q.s2 & sync_q.s3;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_dualbank_pkg::*;
#(
    parameter int             LINES   = 8,
    parameter logic [LINES-1:0] EN_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [1:0]       byte_idx,
    input  logic [7:0]       wdata,
    input  logic [LINES-1:0] pin_lvl,
    input  logic [LINES-1:0] pin_rise,
    input  logic [LINES-1:0] pin_fall,
    output logic [LINES-1:0] en,
    output logic [LINES-1:0] dir,
    output logic [LINES-1:0] drive,
    output logic [LINES-1:0] rise_en,
    output logic [LINES-1:0] fall_en,
    output logic [LINES-1:0] route_irq,
    output logic [LINES-1:0] status,
    output logic [7:0]       rd_byte
);
    localparam int BYTES = (LINES + 7) / 8;

    typedef struct packed {
        logic [LINES-1:0] en;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] rise;
        logic [LINES-1:0] fall;
        logic [LINES-1:0] rirq;
        logic [LINES-1:0] rsmi;
        logic [LINES-1:0] stat;
    } bank_regs_t;

    bank_regs_t r_d, r_q;
    logic [LINES-1:0] line_hit, line_val, upd, clr, set, lvl_view, rd_vec;
    logic [31:0]      rd_pad;

    // Per-line byte decode: line i sits in byte i/8, bit i%8.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_hit[i] = (byte_idx == 2'(i / 8));
        assign line_val[i] = wdata[i % 8];
    end

    always_comb begin
        r_d = r_q;
        upd = line_hit & {LINES{wr_en}};
        clr = '0;
        case (sel)
            SEL_ENABLE:    r_d.en   = (r_q.en   & ~upd) | (line_val & upd);
            SEL_DIR:       r_d.dir  = (r_q.dir  & ~upd) | (line_val & upd);
            SEL_LEVEL:     r_d.lvl  = (r_q.lvl  & ~(upd & ~r_q.dir)) | (line_val & upd & ~r_q.dir);
            SEL_RISE_EN:   r_d.rise = (r_q.rise & ~upd) | (line_val & upd);
            SEL_FALL_EN:   r_d.fall = (r_q.fall & ~upd) | (line_val & upd);
            SEL_IRQ_ROUTE: r_d.rirq = (r_q.rirq & ~upd) | (line_val & upd);
            SEL_SMI_ROUTE: r_d.rsmi = (r_q.rsmi & ~upd) | (line_val & upd);
            default:       clr      = upd & line_val;
        endcase
        set       = r_q.en & ((pin_rise & r_q.rise) | (pin_fall & r_q.fall));
        r_d.stat  = (r_q.stat & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.en  <= EN_INIT;
            r_q.dir <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        lvl_view = r_q.en & ((r_q.dir & pin_lvl) | (~r_q.dir & r_q.lvl));
        case (sel)
            SEL_ENABLE:    rd_vec = r_q.en;
            SEL_DIR:       rd_vec = r_q.dir;
            SEL_LEVEL:     rd_vec = lvl_view;
            SEL_RISE_EN:   rd_vec = r_q.rise;
            SEL_FALL_EN:   rd_vec = r_q.fall;
            SEL_IRQ_ROUTE: rd_vec = r_q.rirq;
            SEL_SMI_ROUTE: rd_vec = r_q.rsmi;
            default:       rd_vec = r_q.stat;
        endcase
        rd_pad  = 32'(rd_vec);
        rd_byte = (int'(byte_idx) < BYTES) ? rd_pad[{byte_idx, 3'b000} +: 8] : 8'h00;
    end

    assign en        = r_q.en;
    assign dir       = r_q.dir;
    assign drive     = r_q.lvl;
    assign rise_en   = r_q.rise;
    assign fall_en   = r_q.fall;
    assign route_irq = r_q.rirq;
    assign status    = r_q.stat;
endmodule

// File: rtl/gpio_dualbank_ctrl.sv
module gpio_dualbank_ctrl
    import gpio_dualbank_pkg::*;
#(
    parameter int           N        = 14,
    parameter int           BOUNDARY = 10,
    parameter logic [N-1:0] EN_INIT  = 14'h1CFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic [N-1:0]      pins_in,
    output logic [N-1:0]      pins_out,
    output logic [N-1:0]      pins_oe,
    output logic              irq
);
    localparam int CORE_W = BOUNDARY;
    localparam int RES_W  = N - BOUNDARY;

    typedef struct packed {
        logic [7:0] rdata;
    } top_regs_t;

    top_regs_t t_d, t_q;

    logic [N-1:0] sync_lvl, sync_rise, sync_fall;
    logic [N-1:0] en_all, dir_all, drv_all, rise_all, fall_all, route_all, stat_all;
    logic [7:0]   core_rd, res_rd;
    reg_sel_e     sel;

    assign sel = reg_sel_e'(addr[4:2]);

    gpio_edge_sync #(.W(N)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(pins_in),
        .pin_lvl  (sync_lvl),
        .pin_rise (sync_rise),
        .pin_fall (sync_fall)
    );

    gpio_bank #(.LINES(CORE_W), .EN_INIT(EN_INIT[CORE_W-1:0])) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en & ~addr[5]),
        .sel      (sel),
        .byte_idx (addr[1:0]),
        .wdata    (wdata),
        .pin_lvl  (sync_lvl[CORE_W-1:0]),
        .pin_rise (sync_rise[CORE_W-1:0]),
        .pin_fall (sync_fall[CORE_W-1:0]),
        .en       (en_all[CORE_W-1:0]),
        .dir      (dir_all[CORE_W-1:0]),
        .drive    (drv_all[CORE_W-1:0]),
        .rise_en  (rise_all[CORE_W-1:0]),
        .fall_en  (fall_all[CORE_W-1:0]),
        .route_irq(route_all[CORE_W-1:0]),
        .status   (stat_all[CORE_W-1:0]),
        .rd_byte  (core_rd)
    );

    gpio_bank #(.LINES(RES_W), .EN_INIT(EN_INIT[N-1:BOUNDARY])) i_resume (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en & addr[5]),
        .sel      (sel),
        .byte_idx (addr[1:0]),
        .wdata    (wdata),
        .pin_lvl  (sync_lvl[N-1:BOUNDARY]),
        .pin_rise (sync_rise[N-1:BOUNDARY]),
        .pin_fall (sync_fall[N-1:BOUNDARY]),
        .en       (en_all[N-1:BOUNDARY]),
        .dir      (dir_all[N-1:BOUNDARY]),
        .drive    (drv_all[N-1:BOUNDARY]),
        .rise_en  (rise_all[N-1:BOUNDARY]),
        .fall_en  (fall_all[N-1:BOUNDARY]),
        .route_irq(route_all[N-1:BOUNDARY]),
        .status   (stat_all[N-1:BOUNDARY]),
        .rd_byte  (res_rd)
    );

    always_comb begin
        t_d = t_q;
        if (rd_en) t_d.rdata = addr[5] ? res_rd : core_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rdata    = t_q.rdata;
    assign pins_out = drv_all;
    assign pins_oe  = en_all & ~dir_all;
    assign irq      = |(stat_all & route_all);
endmodule

// File: rtl/gpio_dualbank_checker.sv
module gpio_dualbank_checker #(
    parameter int N = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         irq,
    input logic [N-1:0] pins_oe,
    input logic [N-1:0] pins_out,
    input logic [N-1:0] en_all,
    input logic [N-1:0] dir_all,
    input logic [N-1:0] rise_all,
    input logic [N-1:0] fall_all,
    input logic [N-1:0] route_all,
    input logic [N-1:0] stat_all
);
    logic [N-1:0] armed;
    assign armed = en_all & (rise_all | fall_all);

    // R1: held in reset, nothing drives and no interrupt is raised
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (irq == 1'b0 && pins_oe == '0);
        end
    end

    // R3: only output lines may drive
    a_r3_oe_outputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_oe & dir_all) == '0);

    // R9: disabled lines never drive
    a_r9_disabled_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_oe & ~en_all) == '0);

    // R4: an input line's driven level cannot change
    a_r4_input_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pins_out ^ $past(pins_out)) & $past(dir_all)) == '0));

    // R6: status clears only through a bus write
    a_r6_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(stat_all) & ~stat_all) == '0));

    // R5: new status bits only on enabled, armed lines
    a_r5_status_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(armed)) == '0));

    // R8: no routed status pending means no interrupt
    a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_all & route_all) == '0) |-> !irq);
endmodule

bind gpio_dualbank_ctrl gpio_dualbank_checker #(.N(N)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .irq      (irq),
    .pins_oe  (pins_oe),
    .pins_out (pins_out),
    .en_all   (en_all),
    .dir_all  (dir_all),
    .rise_all (rise_all),
    .fall_all (fall_all),
    .route_all(route_all),
    .stat_all (stat_all)
);

// File: tb/test_gpio_dualbank_ctrl.sv
module test_gpio_dualbank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [13:0] pins_in = '0;
    logic [13:0] pins_out;
    logic [13:0] pins_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_dualbank_ctrl i_gpio_dualbank_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, 16'(d), 16'(exp));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 pins_oe", 16'(pins_oe), 16'h0);
        chk("R1 pins_out", 16'(pins_out), 16'h0);
        rd_chk("R1 core enable b0", 6'h00, 8'hFF);
        rd_chk("R1 core enable b1", 6'h01, 8'h00);
        rd_chk("R1 resume enable", 6'h20, 8'h07);
        rd_chk("R1 core dir b1", 6'h05, 8'h03);
        rd_chk("R1 resume dir", 6'h24, 8'h0F);
        rd_chk("R1 core status", 6'h1C, 8'h00);
        rd_chk("R1 rise enable", 6'h0C, 8'h00);
    endtask

    task automatic t_disabled();
        // Line 8 (core byte 1 bit 0) is disabled from reset.
        wr(6'h05, 8'h02);
        chk("R9 disabled output not driven", 16'(pins_oe), 16'h0);
        wr(6'h0D, 8'h01);
        pins_in[8] = 1'b1;
        settle();
        rd_chk("R9 disabled no status", 6'h1D, 8'h00);
        rd_chk("R9 disabled level reads 0", 6'h09, 8'h00);
        wr(6'h01, 8'h03);
        chk("R9 enabled output drives", 16'(pins_oe), 16'h0100);
        wr(6'h05, 8'h03);
        chk("R3 back to input", 16'(pins_oe), 16'h0);
    endtask

    task automatic t_map();
        rd_chk("R2 core enable b1", 6'h01, 8'h03);
        wr(6'h20, 8'h0F);
        rd_chk("R2 resume enable", 6'h20, 8'h0F);
        rd_chk("R10 unmapped core byte", 6'h02, 8'h00);
        rd_chk("R10 unmapped resume byte", 6'h21, 8'h00);
        rd_chk("R10 unmapped top", 6'h3F, 8'h00);
    endtask

    task automatic t_dir_level();
        wr(6'h04, 8'hFE);
        chk("R3 line0 output", 16'(pins_oe), 16'h0001);
        wr(6'h08, 8'h01);
        chk("R4 output level", 16'(pins_out), 16'h0001);
        wr(6'h08, 8'h03);
        chk("R4 input level write ignored", 16'(pins_out), 16'h0001);
        pins_in[1] = 1'b1;
        settle();
        rd_chk("R4 level readback", 6'h08, 8'h03);
        pins_in[1] = 1'b0;
        settle();
        // Resume line 12 = local 2
        wr(6'h24, 8'h0B);
        chk("R2 resume line 12 output", 16'(pins_oe), 16'h1001);
        wr(6'h28, 8'h04);
        chk("R2 resume level", 16'(pins_out), 16'h1001);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        wr(6'h0C, 8'h08);
        wr(6'h14, 8'h08);
        @(negedge clk);
        pins_in[3] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 no early status", 16'(irq), 16'h0);
        @(negedge clk);
        chk("R5 status on third edge", 16'(irq), 16'h1);
        rd_chk("R5 rising status", 6'h1C, 8'h08);
        wr(6'h1C, 8'h00);
        rd_chk("R6 write 0 keeps", 6'h1C, 8'h08);
        wr(6'h1C, 8'h08);
        rd_chk("R6 write 1 clears", 6'h1C, 8'h00);
        chk("R8 irq drops", 16'(irq), 16'h0);
        pins_in[3] = 1'b0;
        settle();
        rd_chk("R5 falling ignored with rise only", 6'h1C, 8'h00);
        // both edges on line 2
        wr(6'h0C, 8'h0C);
        wr(6'h10, 8'h04);
        pins_in[2] = 1'b1;
        settle();
        rd_chk("R5 both: rise", 6'h1C, 8'h04);
        wr(6'h1C, 8'h04);
        pins_in[2] = 1'b0;
        settle();
        rd_chk("R5 both: fall", 6'h1C, 8'h04);
        // R7 collision: edge set and clear in the same cycle
        @(negedge clk);
        pins_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        addr = 6'h1C; wdata = 8'h04; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(6'h1C, d);
        chk("R7 set wins", 16'(d), 16'h04);
        wr(6'h1C, 8'h04);
        rd_chk("R7 later clear works", 6'h1C, 8'h00);
        // neither enable on line 4
        pins_in[4] = 1'b1;
        settle();
        pins_in[4] = 1'b0;
        settle();
        rd_chk("R5 no enables no status", 6'h1C, 8'h00);
    endtask

    task automatic t_route();
        // Resume line 11 = local 1, falling edge
        pins_in[11] = 1'b1;
        settle();
        wr(6'h30, 8'h02);
        pins_in[11] = 1'b0;
        settle();
        rd_chk("R5 resume falling status", 6'h3C, 8'h02);
        chk("R8 unrouted no irq", 16'(irq), 16'h0);
        wr(6'h38, 8'h02);
        rd_chk("R8 mgmt route stored", 6'h38, 8'h02);
        chk("R8 mgmt route no irq", 16'(irq), 16'h0);
        wr(6'h34, 8'h02);
        chk("R8 routed irq", 16'(irq), 16'h1);
        wr(6'h3C, 8'h02);
        chk("R8 irq cleared", 16'(irq), 16'h0);
    endtask

    task automatic t_rdata_hold();
        logic [7:0] d;
        rd(6'h20, d);
        wr(6'h20, 8'h01);
        chk("R10 rdata holds without rd_en", 16'(rdata), 16'h0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_map();
        t_dir_level();
        t_edges();
        t_route();
        t_rdata_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule